// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break and Preamble Generation

This block turns parallel words into asynchronous serial characters. A word written by the host lands in a one-entry holding register. On a baud tick, when the shifter has no bits left to send, the word moves into the shift register. The shifter then sends one bit per baud tick, least significant bit first. The frame is a low start bit, eight or nine data bits and a high stop bit. Parity can be enabled: it then takes the place of the last data bit.

Besides data, the shifter sends three special characters, all chosen at a free baud tick:

- **Break:** a break request loads a character of all zeros with no start or stop bit. A held request repeats it back to back.
- **Mark bit:** once the request is released, a single high bit follows before anything else.
- **Preamble:** turning the transmit enable on, including turning it off and then on again, queues a preamble of all ones.

Two flags report progress:

- **Holding-register-empty flag:** shows when the next word may be written.
- **Transmission-complete flag:** shows that the line is idle and that nothing is queued.

The baud-rate generator, the receiver and the register interface sit outside this block.

Top module: `async_tx`

## Requirements
- R1: After reset, and whenever no character is being shifted, `txd` is 1. After reset, `tdre` is 1 and `tc` is 1.
- R2: A data character is sent in this order: a 0 start bit, then the data bits LSB first, then a 1 stop bit. There are 8 data bits when `long_frame`=0 and 9 data bits (`wr_data[8]` last) when `long_frame`=1. Each bit holds `txd` for exactly one baud-tick period. The first bit appears on the clock after the baud tick that loads the character.
- R3: With `parity_en`=1, the last data bit slot carries even parity instead of the data bit. That slot is bit 7 when `long_frame`=0 and bit 8 when `long_frame`=1. Even parity is the XOR of the data bits before that slot.
- R4: A write (`wr_en`=1) stores `wr_data` and drives `tdre` low on the next clock. `tdre` returns high on the clock after the baud tick that moves the word into the shifter. A write in that same cycle keeps `tdre` low.
- R5: If a word is waiting when the last bit of a character ends, its start bit follows on the very next tick, with no idle bit in between.
- R6: Clearing `tx_en` lets the character in progress finish. No new character of any kind (other than the mark bit of R9) is then loaded. A write while disabled only fills the holding register, and `tdre` stays low.
- R7: A 0-to-1 change of `tx_en` queues a preamble of all ones. It is 10 ticks long when `long_frame`=0 and 11 ticks when `long_frame`=1, and it goes out before the next data character. Clearing `tx_en` discards a queued preamble. The enable takes effect one clock after the input changes.
- R8: When `brk_req`=1 and the block is enabled at a free tick, a break is loaded. A break is all zeros with no start, stop or parity bit. It lasts 10 ticks when `long_frame`=0 and 11 ticks when `long_frame`=1.
- R9: While `brk_req` stays 1, breaks follow one another with no gap. After release, the last break finishes and exactly one high mark bit is then sent before any other character.
- R10: `tc` is a register. It is 1 one clock after a cycle in which all of the following hold:
  - the shifter was idle;
  - the holding register was empty;
  - no preamble or mark bit was queued;
  - no enabled break was requested.
- R11: At a free tick, the order of precedence is break, then mark bit, then preamble, then data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| wr_en | input | 1 | Holding-register write strobe |
| wr_data | input | 9 | Word to send; bit 8 used only in long frames |
| long_frame | input | 1 | 0: 8 data bits, 1: 9 data bits |
| parity_en | input | 1 | Replace last data bit with even parity |
| tx_en | input | 1 | Transmitter enable |
| brk_req | input | 1 | Send-break control |
| txd | output | 1 | Serial line |
| tdre | output | 1 | Holding register empty |
| tc | output | 1 | Transmission complete |

## Verification
The bench removes the enable in the middle of a frame and checks two things. The frame must finish, because a design that cut it short would leave `txd` low or stop early. The word written while disabled must stay parked, because a design that loaded it would raise `tdre`. It re-enables the block with a word already waiting. A design that skipped the preamble, or sent it after the data, would put a start bit ten ticks too early. It holds the break request across several break periods and writes data during the break. Any gap between breaks, a missing trailing mark bit, or data that jumps ahead of the break shows up as a bit mismatch on `txd`. Parity is checked in both frame lengths, and back-to-back writes expose any idle bit inserted between characters.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;
  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_BREAK,
    SRC_MARK,
    SRC_PRE,
    SRC_DATA
  } src_e;
endpackage

// File: rtl/async_tx_holdreg.sv
module async_tx_holdreg #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic [DW-1:0] data,
  output logic          empty
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data  <= '0;
      empty <= 1'b1;
    end else begin
      if (wr_en) begin
        data  <= wr_data;
        empty <= 1'b0;
      end else if (take) begin
        empty <= 1'b1;
      end
    end
  end

  // R4: a write always leaves a word waiting
  p_write_fills_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !empty);
  // R4: the flag only rises after the shifter took the word
  p_empty_by_take_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(empty) |-> $past(take));
endmodule

// File: rtl/async_tx_arbiter.sv
module async_tx_arbiter
  import async_tx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic free,
  input  logic tx_en,
  input  logic brk_req,
  input  logic hold_empty,
  output src_e src,
  output logic en_q,
  output logic pre_q,
  output logic tail_q
);
  always_comb begin
    src = SRC_NONE;
    if (tick && free) begin
      if (brk_req && en_q)           src = SRC_BREAK;
      else if (tail_q)               src = SRC_MARK;
      else if (pre_q && en_q)        src = SRC_PRE;
      else if (!hold_empty && en_q)  src = SRC_DATA;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      pre_q  <= 1'b0;
      tail_q <= 1'b0;
    end else begin
      en_q <= tx_en;
      if (src == SRC_BREAK)     tail_q <= 1'b1;
      else if (src == SRC_MARK) tail_q <= 1'b0;
      if (tx_en && !en_q)       pre_q <= 1'b1;
      else if (!tx_en)          pre_q <= 1'b0;
      else if (src == SRC_PRE)  pre_q <= 1'b0;
    end
  end

  // R7: enabling always leaves a preamble queued
  p_pre_on_enable_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q) |-> pre_q);
  // R11: data never overtakes a queued mark or preamble
  p_data_last_r11: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_DATA) |-> (!pre_q && !tail_q));
endmodule

// File: rtl/async_tx_framer.sv
module async_tx_framer
  import async_tx_pkg::*;
#(
  parameter int BASE_W = 8,
  localparam int DW    = BASE_W + 1,
  localparam int FW    = BASE_W + 3,
  localparam int CNT_W = $clog2(FW + 1)
) (
  input  src_e             src,
  input  logic [DW-1:0]    data,
  input  logic             long_frame,
  input  logic             parity_en,
  output logic [FW-1:0]    frame,
  output logic [CNT_W-1:0] len
);
  logic [FW-1:0]    dframe;
  logic [CNT_W-1:0] char_len;
  logic             par;
  int               nd;

  always_comb begin
    nd       = long_frame ? DW : DW - 1;
    char_len = long_frame ? CNT_W'(FW) : CNT_W'(FW - 1);
    par      = 1'b0;
    for (int i = 0; i < DW - 1; i++) begin
      if (i < nd - 1) par = par ^ data[i];
    end
    dframe    = '1;
    dframe[0] = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (parity_en && (i == nd - 1)) dframe[i+1] = par;
      else if (i < nd)                dframe[i+1] = data[i];
    end
  end

  always_comb begin
    unique case (src)
      SRC_BREAK: begin frame = '0;     len = char_len;     end
      SRC_MARK:  begin frame = '1;     len = CNT_W'(1);    end
      SRC_PRE:   begin frame = '1;     len = char_len;     end
      SRC_DATA:  begin frame = dframe; len = char_len;     end
      default:   begin frame = '1;     len = '0;           end
    endcase
  end
endmodule

// File: rtl/async_tx_shifter.sv
module async_tx_shifter #(
  parameter int FW    = 11,
  localparam int CNT_W = $clog2(FW + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [FW-1:0]    frame,
  input  logic [CNT_W-1:0] len,
  output logic             txd,
  output logic             busy,
  output logic             free
);
  logic [FW-1:0]    sh;
  logic [CNT_W-1:0] rem;

  assign free = !busy || (rem == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      txd  <= 1'b1;
      busy <= 1'b0;
      rem  <= '0;
      sh   <= '1;
    end else if (tick) begin
      if (load) begin
        txd  <= frame[0];
        sh   <= {1'b1, frame[FW-1:1]};
        rem  <= len - CNT_W'(1);
        busy <= 1'b1;
      end else if (busy && rem != '0) begin
        txd <= sh[0];
        sh  <= {1'b1, sh[FW-1:1]};
        rem <= rem - CNT_W'(1);
      end else begin
        txd  <= 1'b1;
        busy <= 1'b0;
      end
    end
  end

  // R5: a new character is only loaded once the current one has ended
  p_load_when_free_r5: assert property (@(posedge clk) disable iff (rst)
    load |-> free);
  // R1: an idle shifter holds the line high
  p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
#(
  parameter int BASE_W = 8,
  localparam int DW    = BASE_W + 1,
  localparam int FW    = BASE_W + 3,
  localparam int CNT_W = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          baud_tick,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          long_frame,
  input  logic          parity_en,
  input  logic          tx_en,
  input  logic          brk_req,
  output logic          txd,
  output logic          tdre,
  output logic          tc
);
  src_e             src;
  logic [DW-1:0]    hold_data;
  logic             hold_empty;
  logic             en_q, pre_q, tail_q;
  logic             busy, free;
  logic [FW-1:0]    frame;
  logic [CNT_W-1:0] len;

  async_tx_holdreg #(.DW(DW)) i_hold (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .take(src == SRC_DATA), .data(hold_data), .empty(hold_empty)
  );

  async_tx_arbiter i_arb (
    .clk(clk), .rst(rst), .tick(baud_tick), .free(free), .tx_en(tx_en),
    .brk_req(brk_req), .hold_empty(hold_empty), .src(src), .en_q(en_q),
    .pre_q(pre_q), .tail_q(tail_q)
  );

  async_tx_framer #(.BASE_W(BASE_W)) i_frm (
    .src(src), .data(hold_data), .long_frame(long_frame),
    .parity_en(parity_en), .frame(frame), .len(len)
  );

  async_tx_shifter #(.FW(FW)) i_shf (
    .clk(clk), .rst(rst), .tick(baud_tick), .load(src != SRC_NONE),
    .frame(frame), .len(len), .txd(txd), .busy(busy), .free(free)
  );

  assign tdre = hold_empty;

  always_ff @(posedge clk) begin
    if (rst) tc <= 1'b1;
    else     tc <= !busy && hold_empty && !pre_q && !tail_q && !(brk_req && en_q);
  end

  // R8: a loaded break drives the line low
  p_break_low_r8: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_BREAK) |=> !txd);
  // R9: the mark bit after a break is high
  p_mark_high_r9: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_MARK) |=> txd);
  // R10: completion never coexists with a low line
  p_tc_line_r10: assert property (@(posedge clk) disable iff (rst)
    tc |-> txd);
endmodule

// File: tb/test_async_tx.sv
module test_async_tx;
  localparam int DIV = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic       long_frame = 1'b0;
  logic       parity_en = 1'b0;
  logic       tx_en = 1'b0;
  logic       brk_req = 1'b0;
  logic       txd, tdre, tc;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  int    tcnt = 0;
  string phase = "R1";
  bit    done = 1'b0;

  // reference model state
  int       q[$];
  logic     m_txd = 1'b1, m_busy = 1'b0, m_empty = 1'b1, m_pre = 1'b0;
  logic     m_tail = 1'b0, m_enq = 1'b0, m_tc = 1'b1;
  logic [8:0] m_hold = '0;
  logic     took;
  int       nbit, nd, b, p;

  async_tx i_async_tx (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .long_frame(long_frame), .parity_en(parity_en),
    .tx_en(tx_en), .brk_req(brk_req), .txd(txd), .tdre(tdre), .tc(tc)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    tcnt      <= (tcnt == DIV - 1) ? 0 : tcnt + 1;
    baud_tick <= (tcnt == DIV - 1);
  end

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      m_txd = 1; m_busy = 0; m_empty = 1; m_pre = 0;
      m_tail = 0; m_enq = 0; m_tc = 1; m_hold = '0;
    end else begin
      m_tc = !m_busy && m_empty && !m_pre && !m_tail && !(brk_req && m_enq);
      took = 0;
      if (baud_tick) begin
        if (m_busy && q.size() > 0) m_txd = q.pop_front();
        else begin
          nbit = long_frame ? 11 : 10;
          if (brk_req && m_enq) begin
            for (int i = 0; i < nbit; i++) q.push_back(0);
            m_tail = 1;
          end else if (m_tail) begin
            q.push_back(1);
            m_tail = 0;
          end else if (m_pre && m_enq) begin
            for (int i = 0; i < nbit; i++) q.push_back(1);
            m_pre = 0;
          end else if (!m_empty && m_enq) begin
            nd = long_frame ? 9 : 8;
            p = 0;
            q.push_back(0);
            for (int i = 0; i < nd; i++) begin
              b = m_hold[i];
              if (parity_en && i == nd - 1) b = p;
              else p = p ^ b;
              q.push_back(b);
            end
            q.push_back(1);
            took = 1;
          end
          if (q.size() > 0) begin m_txd = q.pop_front(); m_busy = 1; end
          else begin m_txd = 1; m_busy = 0; end
        end
      end
      if (tx_en && !m_enq) m_pre = 1;
      else if (!tx_en)     m_pre = 0;
      if (wr_en) begin m_hold = wr_data; m_empty = 0; end
      else if (took) m_empty = 1;
      m_enq = tx_en;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual %0d expected %0d at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst && !done) begin
      check(phase, "txd", txd, m_txd);
      check(phase, "tdre", tdre, m_empty);
      check("R10", "tc", tc, m_tc);
    end
    if (cyc > 100000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(input logic [8:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    cycles(3);
    for (int k = 0; k < 2000 && !tc; k++) @(negedge clk);
    cycles(2);
  endtask

  task automatic wait_tdre();
    for (int k = 0; k < 2000 && !tdre; k++) @(negedge clk);
  endtask

  initial begin
    cycles(4);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "txd after reset", txd, 1);
    check("R1", "tdre after reset", tdre, 1);
    check("R1", "tc after reset", tc, 1);

    phase = "R7"; tx_en = 1'b1; cycles(5);
    phase = "R2"; write(9'h0A5);
    check("R4", "tdre after write", tdre, 0);
    wait_idle();

    phase = "R5";
    write(9'h03C); wait_tdre();
    write(9'h10F); wait_tdre();
    write(9'h0C3);
    wait_idle();

    phase = "R3"; parity_en = 1'b1;
    write(9'h007); wait_idle();
    long_frame = 1'b1;
    write(9'h0FF); wait_idle();
    write(9'h1FE); wait_idle();
    phase = "R2"; parity_en = 1'b0;
    write(9'h155); wait_idle();
    long_frame = 1'b0;

    phase = "R6";
    write(9'h081); cycles(10);
    tx_en = 1'b0;
    write(9'h042);
    cycles(60);
    check("R6", "tdre while disabled", tdre, 0);
    check("R6", "line idle while disabled", txd, 1);

    phase = "R7"; tx_en = 1'b1;
    wait_idle();

    phase = "R8"; brk_req = 1'b1; cycles(4); brk_req = 1'b0;
    wait_idle();

    phase = "R9"; brk_req = 1'b1; cycles(1);
    phase = "R11"; write(9'h055);
    cycles(80);
    phase = "R9"; brk_req = 1'b0;
    wait_idle();

    phase = "R8"; long_frame = 1'b1; brk_req = 1'b1; cycles(2); brk_req = 1'b0;
    wait_idle();
    long_frame = 1'b0;

    check("R10", "tc at end", tc, 1);
    check("R1", "tdre at end", tdre, 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule